// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 16-bit pin groups, an A side and a B side, and moves data across them in either direction through a storage stage. The pins are split into two 8-bit halves. Each half has two directions, and each direction has its own three active-low controls: a direction enable, a latch enable and an output enable. A direction's latch is open only while both its direction enable and its latch enable are low. While its direction enable and output enable are both low, the direction drives the far-side pins of its half with the stored value. In every other case it leaves them undriven.

The block is written as a clocked model of the pad level. Each pin is a resolved level, not an inout net. An external agent offers a value and a strength flag per pin. The block reports the resolved level of every pin and whether it is driving that pin itself. A keeper per pin gives bus-hold: a pin that nobody drives keeps the level it resolved to on the previous clock. The latches take their sources from the resolved pin levels, sampled at the clock edge. The path from A to B is therefore one register deep, so the two directions never form a combinational loop. The design does not settle contention between two drivers. When its own driver and the external one are both active, its own value wins. When both directions of a half are enabled together, both drivers are reported on the outputs and nothing arbitrates between them.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clk edge) clears every latch and every keeper to 0. After reset, an undriven pin reads 0, and a pin driven from a latch that has not captured since reset also reads 0.
- R2: While ab_ce_n[h] and ab_le_n[h] are both 0 at a rising edge, the A-to-B latch of half h (bits 8h+7..8h) loads the resolved A level of those bits. When the B pins are driven, the loaded value appears on b_pad after that edge.
- R3: At an edge where ab_ce_n[h] or ab_le_n[h] is 1, the A-to-B latch of half h keeps its value. After ab_le_n rises, the value stored is the one loaded at the last edge before the rise.
- R4: b_drive bits of half h are 1 exactly when ab_ce_n[h]=0 and ab_oe_n[h]=0. In that case those b_pad bits equal the A-to-B latch of half h.
- R5: An undriven B bit (b_drive=0) reads b_ext_val where b_ext_en=1. Where b_ext_en=0 it reads the keeper.
- R6: The keeper of every pin loads that pin's resolved level at each rising edge. A pin released by all drivers therefore keeps the last level it had.
- R7: The controls of half h affect only pin bits 8h+7..8h and the latches of half h.
- R8: The B-to-A direction mirrors R2 to R5, using ba_ce_n, ba_le_n and ba_oe_n. It loads from b_pad and drives a_pad and a_drive.
- R9: The block does not arbitrate. Its own driver overrides an external driver on the same pin. When both directions of a half are enabled, a_drive and b_drive are both 1 for that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_ce_n | input | 2 | A-to-B direction enable per half, active low |
| ab_le_n | input | 2 | A-to-B latch enable per half, active low |
| ab_oe_n | input | 2 | A-to-B output enable per half, active low |
| ba_ce_n | input | 2 | B-to-A direction enable per half, active low |
| ba_le_n | input | 2 | B-to-A latch enable per half, active low |
| ba_oe_n | input | 2 | B-to-A output enable per half, active low |
| a_ext_val | input | 16 | Value offered by the external agent on the A pins |
| a_ext_en | input | 16 | External agent drives the A pin, per bit |
| b_ext_val | input | 16 | Value offered by the external agent on the B pins |
| b_ext_en | input | 16 | External agent drives the B pin, per bit |
| a_pad | output | 16 | Resolved level of the A pins |
| a_drive | output | 16 | Block drives the A pin, per bit |
| b_pad | output | 16 | Resolved level of the B pins |
| b_drive | output | 16 | Block drives the B pin, per bit |

## Verification
The bench builds the block with its default parameters: two halves of eight bits. That gives twelve control inputs, so the bench can walk all 4096 control combinations in sequence. Each combination is paired with arithmetic data and strength patterns. Storage, transparency, keeper recall and contention are each reached from many predecessor states. Directed sequences then pin down the hold after the latch enable rises, the keeper recall after release, the independence of the halves and the driver override.

// File: rtl/xcvr_pkg.sv
// Shared types for the latched bus transceiver.
// Assumes: all control levels are active low.
package xcvr_pkg;

    // One direction's control set for one half.
    typedef struct packed {
        logic ce_n;   // direction enable
        logic le_n;   // latch enable
        logic oe_n;   // output enable
    } dir_ctl_t;

    // Latch gate: open only while both enables are low.
    function automatic logic gate_open(input dir_ctl_t c);
        return (!c.ce_n) && (!c.le_n);
    endfunction

    // Driver active only while the direction and output enables are low.
    function automatic logic drive_on(input dir_ctl_t c);
        return (!c.ce_n) && (!c.oe_n);
    endfunction

endpackage

// File: rtl/xcvr_lane.sv
// One direction of one half: a storage stage that samples the resolved
// source-side pin level while its gate is open, and a driver-enable
// decode for the far side.
// Assumes: src is the resolved pin level and is stable around the clock edge.
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] src,
    output logic [W-1:0] q,
    output logic         drive
);

    logic [W-1:0] store_q;

    // Capture the source while the gate is open, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (gate_open(ctl)) begin
            store_q <= src;
        end
    end

    // Driver enable for the far-side pins.
    always_comb begin
        drive = drive_on(ctl);
    end

    assign q = store_q;

endmodule

// File: rtl/pad_keeper.sv
// Pin resolution for one half of one side, with a bus-hold keeper.
// The block's own driver is strongest, then the external agent, and the
// keeper is weakest.
// Assumes: the keeper is refreshed every clock from the resolved level.
module pad_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         own_drive,
    input  logic [W-1:0] own_val,
    input  logic [W-1:0] ext_en,
    input  logic [W-1:0] ext_val,
    output logic [W-1:0] pad
);

    logic [W-1:0] hold_q;

    // Resolve each pin: own driver, then external driver, then keeper.
    always_comb begin
        for (int k = 0; k < W; k++) begin
            if (own_drive) begin
                pad[k] = own_val[k];
            end else if (ext_en[k]) begin
                pad[k] = ext_val[k];
            end else begin
                pad[k] = hold_q[k];
            end
        end
    end

    // Keeper remembers the last resolved level of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= pad;
        end
    end

endmodule

// File: rtl/bidir_latch_xcvr.sv
// Top of the latched bus transceiver. It holds NUM_HALVES independent
// groups of HALF_W pins, and each group has an A-to-B and a B-to-A lane
// plus a keeper on each side.
// Assumes: latch sources are taken from resolved pin levels, so the
// path is broken by a register and the two directions form no loop.
module bidir_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int HALF_W     = 8,
    parameter int NUM_HALVES = 2,
    localparam int BUS_W     = HALF_W * NUM_HALVES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_HALVES-1:0] ab_ce_n,
    input  logic [NUM_HALVES-1:0] ab_le_n,
    input  logic [NUM_HALVES-1:0] ab_oe_n,
    input  logic [NUM_HALVES-1:0] ba_ce_n,
    input  logic [NUM_HALVES-1:0] ba_le_n,
    input  logic [NUM_HALVES-1:0] ba_oe_n,
    input  logic [BUS_W-1:0]      a_ext_val,
    input  logic [BUS_W-1:0]      a_ext_en,
    input  logic [BUS_W-1:0]      b_ext_val,
    input  logic [BUS_W-1:0]      b_ext_en,
    output logic [BUS_W-1:0]      a_pad,
    output logic [BUS_W-1:0]      a_drive,
    output logic [BUS_W-1:0]      b_pad,
    output logic [BUS_W-1:0]      b_drive
);

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        localparam int LO = h * HALF_W;

        dir_ctl_t     ab_ctl;
        dir_ctl_t     ba_ctl;
        logic [HALF_W-1:0] ab_q;
        logic [HALF_W-1:0] ba_q;
        logic              ab_drv;
        logic              ba_drv;

        // Gather this half's control sets.
        always_comb begin
            ab_ctl = '{ce_n: ab_ce_n[h], le_n: ab_le_n[h], oe_n: ab_oe_n[h]};
            ba_ctl = '{ce_n: ba_ce_n[h], le_n: ba_le_n[h], oe_n: ba_oe_n[h]};
        end

        xcvr_lane #(.W(HALF_W)) u_ab (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ab_ctl),
            .src   (a_pad[LO +: HALF_W]),
            .q     (ab_q),
            .drive (ab_drv)
        );

        xcvr_lane #(.W(HALF_W)) u_ba (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ba_ctl),
            .src   (b_pad[LO +: HALF_W]),
            .q     (ba_q),
            .drive (ba_drv)
        );

        pad_keeper #(.W(HALF_W)) u_keep_a (
            .clk       (clk),
            .rst_n     (rst_n),
            .own_drive (ba_drv),
            .own_val   (ba_q),
            .ext_en    (a_ext_en[LO +: HALF_W]),
            .ext_val   (a_ext_val[LO +: HALF_W]),
            .pad       (a_pad[LO +: HALF_W])
        );

        pad_keeper #(.W(HALF_W)) u_keep_b (
            .clk       (clk),
            .rst_n     (rst_n),
            .own_drive (ab_drv),
            .own_val   (ab_q),
            .ext_en    (b_ext_en[LO +: HALF_W]),
            .ext_val   (b_ext_val[LO +: HALF_W]),
            .pad       (b_pad[LO +: HALF_W])
        );

        // Spread the per-half driver enables over the pins of the half.
        assign a_drive[LO +: HALF_W] = {HALF_W{ba_drv}};
        assign b_drive[LO +: HALF_W] = {HALF_W{ab_drv}};
    end

endmodule

// File: rtl/bidir_latch_xcvr_chk.sv
// Checker for the latched bus transceiver. It relates the pins over
// consecutive clocks and is attached to the top with a bind statement.
module bidir_latch_xcvr_chk #(
    parameter int HALF_W     = 8,
    parameter int NUM_HALVES = 2,
    localparam int BUS_W     = HALF_W * NUM_HALVES
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_HALVES-1:0] ab_ce_n,
    input logic [NUM_HALVES-1:0] ab_le_n,
    input logic [NUM_HALVES-1:0] ba_ce_n,
    input logic [NUM_HALVES-1:0] ba_le_n,
    input logic [BUS_W-1:0]      a_ext_en,
    input logic [BUS_W-1:0]      b_ext_en,
    input logic [BUS_W-1:0]      a_pad,
    input logic [BUS_W-1:0]      a_drive,
    input logic [BUS_W-1:0]      b_pad,
    input logic [BUS_W-1:0]      b_drive
);

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_h
        localparam int LO = h * HALF_W;

        // R2: an open gate at the previous edge shows the previous A level on driven B pins
        a_r2_ab_follow: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!ab_ce_n[h] && !ab_le_n[h]) && b_drive[LO])
            |-> (b_pad[LO +: HALF_W] == $past(a_pad[LO +: HALF_W])));

        // R3: a closed gate keeps driven B pins stable
        a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ab_ce_n[h] || ab_le_n[h]) && b_drive[LO] && $past(b_drive[LO]))
            |-> $stable(b_pad[LO +: HALF_W]));

        // R8: mirrored transparency from B to A
        a_r8_ba_follow: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!ba_ce_n[h] && !ba_le_n[h]) && a_drive[LO])
            |-> (a_pad[LO +: HALF_W] == $past(b_pad[LO +: HALF_W])));

        // R8: mirrored storage from B to A
        a_r8_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ba_ce_n[h] || ba_le_n[h]) && a_drive[LO] && $past(a_drive[LO]))
            |-> $stable(a_pad[LO +: HALF_W]));
    end

    // R5: undriven B pins with no external driver keep the previous level
    a_r5_b_keep: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((b_pad ^ $past(b_pad)) & ~b_drive & ~b_ext_en) == '0));

    // R6: undriven A pins with no external driver keep the previous level
    a_r6_a_keep: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((a_pad ^ $past(a_pad)) & ~a_drive & ~a_ext_en) == '0));

endmodule

bind bidir_latch_xcvr bidir_latch_xcvr_chk #(
    .HALF_W     (HALF_W),
    .NUM_HALVES (NUM_HALVES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ab_ce_n  (ab_ce_n),
    .ab_le_n  (ab_le_n),
    .ba_ce_n  (ba_ce_n),
    .ba_le_n  (ba_le_n),
    .a_ext_en (a_ext_en),
    .b_ext_en (b_ext_en),
    .a_pad    (a_pad),
    .a_drive  (a_drive),
    .b_pad    (b_pad),
    .b_drive  (b_drive)
);

// File: tb/bidir_latch_xcvr_tb.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
    logic [15:0] a_ext_val, a_ext_en, b_ext_val, b_ext_en;
    logic [15:0] a_pad, a_drive, b_pad, b_drive;

    int total = 0;
    int bad = 0;
    int cont_seen = 0;
    int cont_exp = 0;
    bit finished = 1'b0;

    // Reference state written from the requirements.
    logic [7:0]  m_lab [2];
    logic [7:0]  m_lba [2];
    logic [15:0] m_ka, m_kb;

    always #2 clk = ~clk;

    bidir_latch_xcvr u_dut (
        .clk(clk), .rst_n(rst_n),
        .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_ext_val(a_ext_val), .a_ext_en(a_ext_en),
        .b_ext_val(b_ext_val), .b_ext_en(b_ext_en),
        .a_pad(a_pad), .a_drive(a_drive), .b_pad(b_pad), .b_drive(b_drive)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ab_ce_n = 2'b11; ab_le_n = 2'b11; ab_oe_n = 2'b11;
        ba_ce_n = 2'b11; ba_le_n = 2'b11; ba_oe_n = 2'b11;
        a_ext_val = '0; a_ext_en = '0; b_ext_val = '0; b_ext_en = '0;
    endtask

    // Expected pin levels and driver enables from current inputs and state.
    task automatic predict(output logic [15:0] ea, output logic [15:0] eb,
                           output logic [15:0] eda, output logic [15:0] edb);
        for (int h = 0; h < 2; h++) begin
            logic bd, ad;
            bd = !ab_ce_n[h] && !ab_oe_n[h];
            ad = !ba_ce_n[h] && !ba_oe_n[h];
            edb[h*8 +: 8] = {8{bd}};
            eda[h*8 +: 8] = {8{ad}};
            for (int k = h*8; k < h*8+8; k++) begin
                eb[k] = bd ? m_lab[h][k-h*8] : (b_ext_en[k] ? b_ext_val[k] : m_kb[k]);
                ea[k] = ad ? m_lba[h][k-h*8] : (a_ext_en[k] ? a_ext_val[k] : m_ka[k]);
            end
        end
    endtask

    // One cycle: check outputs before the edge, advance the model, return at negedge.
    task automatic cyc();
        logic [15:0] ea, eb, eda, edb;
        predict(ea, eb, eda, edb);
        #1;
        chk("R4 b_drive", b_drive, edb);
        chk("R8 a_drive", a_drive, eda);
        chk("R2/R3/R5 b_pad", b_pad, eb);
        chk("R8/R6 a_pad", a_pad, ea);
        for (int h = 0; h < 2; h++) begin
            if (a_drive[h*8] && b_drive[h*8]) cont_seen++;
            if (eda[h*8] && edb[h*8]) cont_exp++;
        end
        @(posedge clk);
        for (int h = 0; h < 2; h++) begin
            if (!ab_ce_n[h] && !ab_le_n[h]) m_lab[h] = ea[h*8 +: 8];
            if (!ba_ce_n[h] && !ba_le_n[h]) m_lba[h] = eb[h*8 +: 8];
        end
        m_ka = ea;
        m_kb = eb;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        m_lab[0] = '0; m_lab[1] = '0; m_lba[0] = '0; m_lba[1] = '0;
        m_ka = '0; m_kb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: after reset nothing driven and keepers read zero
        chk("R1 a_pad after reset", a_pad, 16'h0000);
        chk("R1 b_pad after reset", b_pad, 16'h0000);
        chk("R1 drives after reset", a_drive | b_drive, 16'h0000);
        @(negedge clk);
        // R1: driving an untouched latch shows zero
        ab_ce_n = 2'b00; ab_oe_n = 2'b00;
        a_ext_en = 16'hFFFF; a_ext_val = 16'hFFFF;
        cyc();
        chk("R1 latch zero after reset", b_pad, 16'h0000);
        idle();
        cyc();

        // R2/R3: open half 0 with A5, then raise latch enable with new data
        ab_ce_n[0] = 1'b0; ab_le_n[0] = 1'b0; ab_oe_n[0] = 1'b0;
        a_ext_en = 16'hFFFF; a_ext_val = 16'h77A5;
        cyc();
        chk("R2 transparent capture", {8'h00, b_pad[7:0]}, 16'h00A5);
        ab_le_n[0] = 1'b1; a_ext_val = 16'h113C;
        cyc();
        chk("R3 stored after le rise", {8'h00, b_pad[7:0]}, 16'h00A5);
        // R7: half 1 untouched by half 0 controls
        chk("R7 half1 undriven", b_drive & 16'hFF00, 16'h0000);
        chk("R7 half1 keeper", b_pad & 16'hFF00, 16'h0000);
        // R5/R6: release B pins; keeper recalls last driven level
        ab_ce_n[0] = 1'b1;
        cyc();
        cyc();
        chk("R6 keeper after release", {8'h00, b_pad[7:0]}, 16'h00A5);
        chk("R5 undriven", b_drive, 16'h0000);
        b_ext_en = 16'h000F; b_ext_val = 16'h0003;
        cyc();
        chk("R5 external over keeper", {8'h00, b_pad[7:0]}, 16'h00A3);
        // R3: direction enable high held the latch against new A data
        b_ext_en = 16'h0000;
        ab_ce_n[0] = 1'b0; ab_le_n[0] = 1'b1; ab_oe_n[0] = 1'b0;
        cyc();
        chk("R3 held through ce high", {8'h00, b_pad[7:0]}, 16'h00A5);
        // R9: own driver beats external, contention reported on both sides
        b_ext_en = 16'hFFFF; b_ext_val = 16'h5A5A;
        ba_ce_n[0] = 1'b0; ba_oe_n[0] = 1'b0;
        cyc();
        chk("R9 own drive wins", b_pad, 16'h5AA5);
        chk("R9 both directions driving", a_drive & b_drive, 16'h00FF);
        idle();
        cyc();

        // Sweep every combination of the twelve control inputs.
        for (int i = 0; i < 4096; i++) begin
            logic [11:0] c;
            c = i[11:0];
            for (int h = 0; h < 2; h++) begin
                ab_ce_n[h] = c[h*6+0]; ab_le_n[h] = c[h*6+1]; ab_oe_n[h] = c[h*6+2];
                ba_ce_n[h] = c[h*6+3]; ba_le_n[h] = c[h*6+4]; ba_oe_n[h] = c[h*6+5];
            end
            a_ext_val = 16'(i * 40503 + 17);
            b_ext_val = 16'(i * 25173 + 91);
            a_ext_en  = 16'(i * 2654 + 3) & 16'(i * 7);
            b_ext_en  = 16'(i * 3371) | 16'(i >> 3);
            cyc();
        end
        chk("R9 contention count", 16'(cont_seen), 16'(cont_exp));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule